// File: doc/BRIEF.md
# Half-Duplex Two-Wire Register Access Master

This block is the master side of a serial register interface for a sensor that has only two wires: a serial clock that the master drives and one data line that both ends share. The host asks for one register access at a time. A write sends an address byte and then a data byte, and the master drives the data line for both. A read sends the address byte, lets go of the line for one idle half-clock, and then clocks in the device's reply on that same line.

The block produces pad-side signals for an external tristate buffer. These are a serial clock, an output bit and an output-enable, and the buffer returns the line value on an input. The serial clock idles low. Its half period is set by a divider input. The master changes its output bit on falling edges. The device samples on rising edges, and the master samples read data on rising edges. Both bytes go most-significant bit first. The first address bit is the direction bit: 1 for read, 0 for write. The remaining seven bits are the register number.

The request side is a valid/ready handshake. A request is taken on a cycle where `req_valid` and `req_ready` are both high, and `req_ready` is low for the whole of a transfer, so the host must hold its request until it is taken. The response side has no back-pressure. `done` is high for exactly one cycle, and `rsp_rdata` is valid on that cycle.

Top module: `hdx_master`

## Requirements
- R1: Out of reset and between transfers, `pad_sclk` and `pad_oe` are low, `busy` and `done` are low, and `req_ready` is high.
- R2: A request is taken only when `req_valid` and `req_ready` are both high. `req_ready` equals not `busy`. A `req_valid` raised during a transfer starts nothing and writes no register.
- R3: The first byte on the line is `{req_rw, req_addr[6:0]}`, sent MSB first. `req_rw` = 1 means read and 0 means write.
- R4: In a write, the eight bits of `req_wdata` follow the address byte MSB first, and `pad_oe` stays high from the first address bit to the last data bit.
- R5: `pad_sdo` changes only while `pad_sclk` is low. It is stable at every rising edge while `pad_oe` is high.
- R6: Each half period of `pad_sclk` lasts `half_div`+1 system clocks, so one serial bit takes 2·(`half_div`+1) clocks.
- R7: In a read, `pad_oe` falls at the falling edge that ends the last address bit. The first read rising edge comes 2·(`half_div`+1) clocks later, with `pad_sclk` held low in between. `pad_oe` stays low through the reply.
- R8: In a read, the line is sampled on eight rising edges, and the first bit sampled becomes bit 7 of `rsp_rdata`.
- R9: `done` is high for one system clock, on the cycle where `busy` has just fallen. For a read, `rsp_rdata` holds the reply on that cycle.
- R10: After every transfer, `pad_oe` is low again, which releases the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| half_div | input | DIV_W | Serial clock half period minus one, in system clocks |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be taken |
| req_rw | input | 1 | 1 = read, 0 = write |
| req_addr | input | ADDR_W | Register number |
| req_wdata | input | DATA_W | Write data |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Transfer in progress |
| rsp_rdata | output | DATA_W | Read data, valid when done is high |
| pad_sclk | output | 1 | Serial clock to the device |
| pad_sdo | output | 1 | Master output bit |
| pad_oe | output | 1 | Master drives the data line when high |
| pad_sdi | input | 1 | Data line value seen at the pad |

## Verification
The assertions assume that `half_div` stays constant while `busy` is high. They also assume that the device never drives the line before the master releases it, because the divider bound and the output-hold checks only hold under these conditions. The bench changes `half_div` only between transfers. Its device model drives the line only after it has seen eight address rising edges with a read bit, and it starts driving one system clock after the master's release edge. A monitor counts any cycle in which both sides drive at once.

// File: rtl/hdx_pkg.sv
package hdx_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_WDATA,
    S_TURN,
    S_RDATA
  } hdx_state_e;
endpackage

// File: rtl/hdx_halfclk.sv
module hdx_halfclk #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == half_div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run || tick)   cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  // R6: the counter never passes the programmed half period
  a_r6_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= half_div));
endmodule

// File: rtl/hdx_shreg.sv
module hdx_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         sin,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= load_val;
    else if (shift) q <= {q[W-2:0], sin};
  end

  // R4: load and shift never compete in one cycle
  a_r4_one_op: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && shift));
endmodule

// File: rtl/hdx_master.sv
module hdx_master
  import hdx_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  half_div,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_rw,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic              busy,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              pad_sclk,
  output logic              pad_sdo,
  output logic              pad_oe,
  input  logic              pad_sdi
);
  localparam int FRAME_W = ADDR_W + 1;
  localparam int SH_W    = (FRAME_W > DATA_W) ? FRAME_W : DATA_W;
  localparam int CNT_W   = $clog2(SH_W + 1);
  localparam logic [CNT_W-1:0] LAST_A = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] LAST_D = CNT_W'(DATA_W - 1);

  hdx_state_e        state_q;
  logic              sclk_q, oe_q, rd_q, done_q;
  logic [CNT_W-1:0]  bitn_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [SH_W-1:0]   sh_q, sh_val;
  logic              tick, rise_tick, fall_tick, last_bit, accept;
  logic              sh_load, sh_shift, run;

  assign busy      = (state_q != S_IDLE);
  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign run       = busy;
  assign rise_tick = tick && !sclk_q;
  assign fall_tick = tick && sclk_q;
  assign last_bit  = (state_q == S_ADDR) ? (bitn_q == LAST_A) : (bitn_q == LAST_D);

  hdx_halfclk #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .half_div(half_div), .tick(tick)
  );

  always_comb begin
    sh_val = '0;
    if (accept) sh_val[SH_W-1 -: FRAME_W] = {req_rw, req_addr};
    else        sh_val[SH_W-1 -: DATA_W]  = wdata_q;
  end

  assign sh_load  = accept ||
                    (state_q == S_ADDR && fall_tick && last_bit && !rd_q);
  assign sh_shift = (fall_tick && !last_bit &&
                     (state_q == S_ADDR || state_q == S_WDATA)) ||
                    (rise_tick && state_q == S_RDATA);

  hdx_shreg #(.W(SH_W)) u_sh (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .load_val(sh_val),
    .shift(sh_shift), .sin(pad_sdi), .q(sh_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      sclk_q  <= 1'b0;
      oe_q    <= 1'b0;
      rd_q    <= 1'b0;
      done_q  <= 1'b0;
      bitn_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (accept) begin
          state_q <= S_ADDR;
          rd_q    <= req_rw;
          wdata_q <= req_wdata;
          oe_q    <= 1'b1;
          sclk_q  <= 1'b0;
          bitn_q  <= '0;
        end
        S_ADDR, S_WDATA: if (tick) begin
          sclk_q <= !sclk_q;
          if (sclk_q) begin
            if (!last_bit) bitn_q <= bitn_q + 1'b1;
            else if (state_q == S_WDATA) begin
              state_q <= S_IDLE;
              oe_q    <= 1'b0;
              done_q  <= 1'b1;
            end else if (rd_q) begin
              state_q <= S_TURN;
              oe_q    <= 1'b0;
            end else begin
              state_q <= S_WDATA;
              bitn_q  <= '0;
            end
          end
        end
        S_TURN: if (tick) begin
          state_q <= S_RDATA;
          bitn_q  <= '0;
        end
        S_RDATA: if (tick) begin
          sclk_q <= !sclk_q;
          if (sclk_q) begin
            if (!last_bit) bitn_q <= bitn_q + 1'b1;
            else begin
              state_q <= S_IDLE;
              rdata_q <= sh_q[DATA_W-1:0];
              done_q  <= 1'b1;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign pad_sclk  = sclk_q;
  assign pad_oe    = oe_q;
  assign pad_sdo   = sh_q[SH_W-1];
  assign done      = done_q;
  assign rsp_rdata = rdata_q;

  a_r5_sdo_hold_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pad_sclk) && pad_oe) |-> $stable(pad_sdo));
  a_r7_turn_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_TURN) |-> (!pad_oe && !pad_sclk));
  a_r7_reply_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_RDATA) |-> !pad_oe);
  a_r4_write_driven: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_ADDR || state_q == S_WDATA) |-> pad_oe);
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!pad_sclk && !pad_oe));
  a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);
endmodule

// File: tb/hdx_master_test.sv
module hdx_master_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] half_div = 8'd1;
  logic req_valid = 1'b0, req_rw = 1'b0;
  logic [6:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, done, busy, pad_sclk, pad_sdo, pad_oe, pad_sdi;
  logic [7:0] rsp_rdata;

  int compared = 0, mismatched = 0, cyc = 0;
  bit finished = 0;

  // device model state
  logic [7:0] mem [0:127];
  logic [7:0] dsh_a = '0, dsh_d = '0, last_frame = '0;
  logic drd = 1'b0, dev_drv = 1'b0, dev_bit = 1'b0;
  int dcnt = 0, dev_txn = 0, contention = 0, oe_fall_cyc = 0, turn_gap = 0;
  int last_rise = 0, period = 0, oe_gaps = 0;
  bit wr_active = 0;

  always #(CLK_PERIOD/2) clk = !clk;

  assign pad_sdi = pad_oe ? pad_sdo : (dev_drv ? dev_bit : 1'b1);

  hdx_master uut (
    .clk(clk), .rst_n(rst_n), .half_div(half_div),
    .req_valid(req_valid), .req_ready(req_ready), .req_rw(req_rw),
    .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .busy(busy),
    .rsp_rdata(rsp_rdata), .pad_sclk(pad_sclk), .pad_sdo(pad_sdo),
    .pad_oe(pad_oe), .pad_sdi(pad_sdi)
  );

  always @(negedge clk) begin
    cyc++;
    if (pad_oe && dev_drv) contention++;
    if (wr_active && busy && !pad_oe) oe_gaps++;
  end
  always @(negedge pad_oe) oe_fall_cyc = cyc;

  always @(posedge pad_sclk) begin
    period = cyc - last_rise;
    last_rise = cyc;
    dcnt = dcnt + 1;
    if (dcnt <= 8) begin
      dsh_a = {dsh_a[6:0], pad_sdi};
      if (dcnt == 1) drd = pad_sdi;
    end else if (drd) begin
      if (dcnt == 9) turn_gap = cyc - oe_fall_cyc;
    end else begin
      dsh_d = {dsh_d[6:0], pad_sdi};
      if (dcnt == 16) begin
        mem[dsh_a[6:0]] = dsh_d;
        last_frame = dsh_a;
        dcnt = 0;
        dev_txn++;
      end
    end
  end

  always @(negedge pad_sclk) begin
    if (drd && dcnt == 8) begin
      dev_bit = mem[dsh_a[6:0]][7];
      #(CLK_PERIOD);
      dev_drv = 1'b1;
    end else if (drd && dcnt > 8 && dcnt < 16) begin
      dev_bit = mem[dsh_a[6:0]][15 - dcnt];
    end else if (drd && dcnt == 16) begin
      dev_drv = 1'b0;
      last_frame = dsh_a;
      dcnt = 0;
      drd = 1'b0;
      dev_txn++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_xfer(input logic rw, input logic [6:0] a, input logic [7:0] d,
                         output logic [7:0] rd);
    int n = 0;
    @(negedge clk);
    req_valid = 1'b1; req_rw = rw; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    chk("R9 done seen", 32'(done), 32'd1);
    rd = rsp_rdata;
    chk("R9 busy low with done", 32'(busy), 32'd0);
    @(negedge clk);
    chk("R9 done one cycle", 32'(done), 32'd0);
    chk("R10 line released", 32'(pad_oe), 32'd0);
    chk("R1 sclk idle low", 32'(pad_sclk), 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 sclk", 32'(pad_sclk), 0);
    chk("R1 oe", 32'(pad_oe), 0);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 ready", 32'(req_ready), 1);
  endtask

  task automatic t_write(input logic [6:0] a, input logic [7:0] d);
    logic [7:0] rd;
    oe_gaps = 0; wr_active = 1;
    do_xfer(1'b0, a, d, rd);
    wr_active = 0;
    chk("R3 write frame", 32'(last_frame), 32'({1'b0, a}));
    chk("R4 data stored", 32'(mem[a]), 32'(d));
    chk("R4 oe held", 32'(oe_gaps), 0);
    chk("R6 bit period", 32'(period), 32'(2 * (half_div + 1)));
  endtask

  task automatic t_read(input logic [6:0] a, input logic [7:0] v);
    logic [7:0] rd;
    mem[a] = v;
    do_xfer(1'b1, a, 8'h00, rd);
    chk("R3 read frame", 32'(last_frame), 32'({1'b1, a}));
    chk("R8 read data", 32'(rd), 32'(v));
    chk("R7 turnaround gap", 32'(turn_gap), 32'(2 * (half_div + 1)));
    chk("R6 bit period", 32'(period), 32'(2 * (half_div + 1)));
  endtask

  task automatic t_ignored();
    int t0;
    logic [7:0] keep;
    keep = mem[7'h22];
    t0 = dev_txn;
    @(negedge clk);
    req_valid = 1'b1; req_rw = 1'b0; req_addr = 7'h11; req_wdata = 8'h3C;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (20) @(negedge clk);
    chk("R2 ready low while busy", 32'(req_ready), 0);
    req_valid = 1'b1; req_addr = 7'h22; req_wdata = 8'hEE;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    repeat (60) @(negedge clk);
    chk("R2 one transfer only", 32'(dev_txn - t0), 1);
    chk("R2 ignored target intact", 32'(mem[7'h22]), 32'(keep));
    chk("R4 first write kept", 32'(mem[7'h11]), 32'h3C);
    chk("R1 idle after", 32'(busy), 0);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 8'(i * 37 + 5);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_write(7'h05, 8'hA5);
    t_write(7'h7F, 8'h01);
    t_read(7'h05, 8'h96);
    t_read(7'h00, 8'hFF);
    half_div = 8'd4;
    t_write(7'h40, 8'h80);
    t_read(7'h2A, 8'h5A);
    half_div = 8'd0;
    t_read(7'h13, 8'h01);
    half_div = 8'd2;
    t_ignored();
    chk("R7 no contention", 32'(contention), 0);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      compared++; mismatched++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule